// File: doc/BRIEF.md
# Bitfield ALU with Compare-Flag Mode

A 32-bit arithmetic and logic unit whose result is captured in an output register one clock after its operands are presented. Beyond add, subtract, the logic functions and the shifts, it offers a rotate, a 10-bit literal shift-in, a bitfield insert and two bitfield extracts, and a bit permutation built from five optional swap stages. Bitfield ops take their field placement from operand B: bits 4..0 give the position, bits 8..5 give the length, and a length code of zero stands for 16 bits.

A compare-mode input turns the same datapath into a flag generator. The operation is still evaluated, but instead of the value the unit returns a 7-bit flag word, computed at byte, halfword or word width and padded with zeros. A processor pipeline uses it as its execute stage. It feeds operands already read from the register file and immediates already sign-extended. It writes either the value or the flag word to the destination register.

Top module: `bitfield_alu`

## Requirements
- R1: While `rst` is high at a clock edge, `result_q` and `illegal_q` become zero after that edge, whatever the other inputs are.
- R2: With `cmp_mode`=0, op codes 0, 2, 4, 5, 6, 7 give A+B, A-B, A&B, A|B, A^B and ~(A^B), modulo 2^32.
- R3: Op code 1 rotates A right, 8 shifts A left, 9 shifts A right logically and A shifts A right arithmetically, each by B[4:0] only; op code 3 gives (A<<10) | B[9:0].
- R4: Op code B replaces the field of A at position B[4:0] and length B[8:5] (0 meaning 16) with the low bits of B>>10; bits of A outside the field and bits of the field beyond bit 31 are untouched.
- R5: Op code C returns (A>>position) cut to the field length and sign-extended from its top bit; op code D returns the same field zero-extended.
- R6: Op code E applies, for each k in 0..4 with B[k]=1 and in rising k order, a swap of neighbouring 2^k-bit blocks; output bit i equals A bit (i XOR B[4:0]).
- R7: With `cmp_mode`=1 and a legal op code, bits 31..7 of the result are zero and bits 6..0 hold above, greater, greater-or-equal, sign, overflow, carry, zero from bit 6 down to bit 0.
- R8: `width_sel` 0, 1, 2 and 3 select 8, 16, 32 and 32-bit evaluation; zero is set when the operation value masked to that width is zero, and sign is its top bit at that width.
- R9: Carry is the bit just above the width in the sum (op 0) or difference (op 2) of A and B, each masked to the width, and is zero for every other op; overflow is set when the sign differs from A's top bit and A's and B's top bits differ.
- R10: Above is (not carry and not zero), greater-or-equal is (sign equals overflow), and greater is (greater-or-equal and not zero).
- R11: Op code F sets `illegal_q` and forces `result_q` to zero in both modes; every other op code clears `illegal_q`.
- R12: The outputs change only at a clock edge and reflect the inputs sampled at the edge just before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B; also carries shift amount, field placement and insert data |
| op_code | input | 4 | Operation select, 0 to F |
| cmp_mode | input | 1 | 1 returns the flag word instead of the value |
| width_sel | input | 2 | Compare width: 0 byte, 1 halfword, 2 or 3 word |
| result_q | output | 32 | Registered value or flag word |
| illegal_q | output | 1 | Registered unsupported-op indication |

## Verification
The bench builds the unit with its default parameters: 32-bit data, a 4-bit length code and a 10-bit shift-in. That width keeps a cross product of thirteen boundary operands for A and B small enough to run every one through all sixteen op codes, in value mode and at all four compare widths. This covers the sign and carry boundaries of each width, the zero length code, fields that run past bit 31 and every swap stage. A run of pseudo-random operands follows, together with a reset applied under live inputs and a check that outputs stay put between edges.

// File: rtl/bfalu_pkg.sv
package bfalu_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'h0,
    OP_ROR   = 4'h1,
    OP_SUB   = 4'h2,
    OP_SHIN  = 4'h3,
    OP_AND   = 4'h4,
    OP_OR    = 4'h5,
    OP_XOR   = 4'h6,
    OP_XNOR  = 4'h7,
    OP_SHL   = 4'h8,
    OP_SHR   = 4'h9,
    OP_SRA   = 4'hA,
    OP_FINS  = 4'hB,
    OP_FEXS  = 4'hC,
    OP_FEXZ  = 4'hD,
    OP_SWAP  = 4'hE,
    OP_BAD   = 4'hF
  } op_t;

  // Flag word, MSB first: above at bit 6 down to zero at bit 0
  typedef struct packed {
    logic above;
    logic gt;
    logic ge;
    logic sign;
    logic ovf;
    logic carry;
    logic zero;
  } flags_t;

  localparam int FLAG_W = $bits(flags_t);
  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

endpackage

// File: rtl/bfalu_shift.sv
module bfalu_shift #(
  parameter int DATA_W = 32,
  parameter int SH_W   = 5,
  parameter int SHIN_W = 10
) (
  input  logic [DATA_W-1:0] a,
  input  logic [SH_W-1:0]   amt,
  input  logic [SHIN_W-1:0] lit,
  output logic [DATA_W-1:0] rot_r,
  output logic [DATA_W-1:0] shl,
  output logic [DATA_W-1:0] shr,
  output logic [DATA_W-1:0] sra,
  output logic [DATA_W-1:0] shin
);
  logic [2*DATA_W-1:0] doubled;

  always_comb begin
    doubled = {a, a} >> amt;
    rot_r   = doubled[DATA_W-1:0];
    shl     = a << amt;
    shr     = a >> amt;
    sra     = $unsigned($signed(a) >>> amt);
    shin    = {a[DATA_W-SHIN_W-1:0], lit};
  end
endmodule

// File: rtl/bfalu_field.sv
module bfalu_field #(
  parameter int DATA_W = 32,
  parameter int SH_W   = 5,
  parameter int LEN_W  = 4,
  parameter int SHIN_W = 10
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] ins,
  output logic [DATA_W-1:0] ext_s,
  output logic [DATA_W-1:0] ext_z
);
  localparam int LV_W = LEN_W + 1;

  logic [SH_W-1:0]   pos;
  logic [LEN_W-1:0]  lcode;
  logic [LV_W-1:0]   lenv;
  logic [DATA_W-1:0] low_mask;
  logic [DATA_W-1:0] fmask;
  logic [DATA_W-1:0] src;
  logic [DATA_W-1:0] raw;
  logic              sbit;

  always_comb begin
    pos      = b[SH_W-1:0];
    lcode    = b[SH_W+LEN_W-1:SH_W];
    lenv     = (lcode == '0) ? LV_W'(1 << LEN_W) : {1'b0, lcode};
    low_mask = (DATA_W'(1) << lenv) - DATA_W'(1);
    fmask    = low_mask << pos;
    src      = b >> SHIN_W;
    ins      = (a & ~fmask) | ((src << pos) & fmask);
    raw      = (a >> pos) & low_mask;
    sbit     = raw[lenv-LV_W'(1)];
    ext_z    = raw;
    ext_s    = sbit ? (raw | ~low_mask) : raw;
  end
endmodule

// File: rtl/bfalu_swap.sv
module bfalu_swap #(
  parameter int DATA_W = 32,
  parameter int SH_W   = 5
) (
  input  logic [DATA_W-1:0] a,
  input  logic [SH_W-1:0]   sel,
  output logic [DATA_W-1:0] y
);
  logic [DATA_W-1:0] stage [0:SH_W];

  assign stage[0] = a;

  genvar k, i;
  generate
    for (k = 0; k < SH_W; k++) begin : g_stage
      for (i = 0; i < DATA_W; i++) begin : g_bit
        assign stage[k+1][i] = sel[k] ? stage[k][i ^ (1 << k)] : stage[k][i];
      end
    end
  endgenerate

  assign y = stage[SH_W];
endmodule

// File: rtl/bfalu_flags.sv
module bfalu_flags
  import bfalu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = 5
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] res,
  input  logic [1:0]        width_sel,
  input  logic              is_add,
  input  logic              is_sub,
  output flags_t            fl
);
  logic [DATA_W-1:0] m;
  logic [SH_W-1:0]   msb_idx;
  logic [SH_W:0]     top_idx;
  logic [DATA_W:0]   sum_x;
  logic [DATA_W:0]   dif_x;
  logic              ahi;
  logic              bhi;

  always_comb begin
    unique case (width_sel)
      2'd0: begin
        m       = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
        msb_idx = SH_W'(BYTE_W - 1);
        top_idx = (SH_W+1)'(BYTE_W);
      end
      2'd1: begin
        m       = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
        msb_idx = SH_W'(HALF_W - 1);
        top_idx = (SH_W+1)'(HALF_W);
      end
      default: begin
        m       = '1;
        msb_idx = SH_W'(DATA_W - 1);
        top_idx = (SH_W+1)'(DATA_W);
      end
    endcase

    sum_x = {1'b0, a & m} + {1'b0, b & m};
    dif_x = {1'b0, a & m} - {1'b0, b & m};
    ahi   = a[msb_idx];
    bhi   = b[msb_idx];

    fl.zero  = ((res & m) == '0);
    fl.sign  = res[msb_idx];
    fl.carry = is_add ? sum_x[top_idx] : (is_sub ? dif_x[top_idx] : 1'b0);
    fl.ovf   = (fl.sign != ahi) && (ahi != bhi);
    fl.ge    = (fl.sign == fl.ovf);
    fl.gt    = fl.ge && !fl.zero;
    fl.above = !fl.carry && !fl.zero;
  end
endmodule

// File: rtl/bitfield_alu.sv
module bitfield_alu
  import bfalu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 4,
  parameter int SHIN_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [3:0]        op_code,
  input  logic              cmp_mode,
  input  logic [1:0]        width_sel,
  output logic [DATA_W-1:0] result_q,
  output logic              illegal_q
);
  localparam int SH_W = $clog2(DATA_W);

  op_t               op;
  logic [DATA_W-1:0] rot_r, shl, shr, sra, shin;
  logic [DATA_W-1:0] f_ins, f_exs, f_exz;
  logic [DATA_W-1:0] swapped;
  logic [DATA_W-1:0] value;
  logic [DATA_W-1:0] next_q;
  logic              bad;
  flags_t            fl;

  assign op = op_t'(op_code);

  bfalu_shift #(.DATA_W(DATA_W), .SH_W(SH_W), .SHIN_W(SHIN_W)) u_shift (
    .a(op_a), .amt(op_b[SH_W-1:0]), .lit(op_b[SHIN_W-1:0]),
    .rot_r(rot_r), .shl(shl), .shr(shr), .sra(sra), .shin(shin)
  );

  bfalu_field #(.DATA_W(DATA_W), .SH_W(SH_W), .LEN_W(LEN_W), .SHIN_W(SHIN_W)) u_field (
    .a(op_a), .b(op_b), .ins(f_ins), .ext_s(f_exs), .ext_z(f_exz)
  );

  bfalu_swap #(.DATA_W(DATA_W), .SH_W(SH_W)) u_swap (
    .a(op_a), .sel(op_b[SH_W-1:0]), .y(swapped)
  );

  bfalu_flags #(.DATA_W(DATA_W), .SH_W(SH_W)) u_flags (
    .a(op_a), .b(op_b), .res(value), .width_sel(width_sel),
    .is_add(op == OP_ADD), .is_sub(op == OP_SUB), .fl(fl)
  );

  always_comb begin
    bad = 1'b0;
    unique case (op)
      OP_ADD:  value = op_a + op_b;
      OP_ROR:  value = rot_r;
      OP_SUB:  value = op_a - op_b;
      OP_SHIN: value = shin;
      OP_AND:  value = op_a & op_b;
      OP_OR:   value = op_a | op_b;
      OP_XOR:  value = op_a ^ op_b;
      OP_XNOR: value = ~(op_a ^ op_b);
      OP_SHL:  value = shl;
      OP_SHR:  value = shr;
      OP_SRA:  value = sra;
      OP_FINS: value = f_ins;
      OP_FEXS: value = f_exs;
      OP_FEXZ: value = f_exz;
      OP_SWAP: value = swapped;
      default: begin
        value = '0;
        bad   = 1'b1;
      end
    endcase

    if (bad)           next_q = '0;
    else if (cmp_mode) next_q = {{(DATA_W-FLAG_W){1'b0}}, fl};
    else               next_q = value;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q  <= '0;
      illegal_q <= 1'b0;
    end else begin
      result_q  <= next_q;
      illegal_q <= bad;
    end
  end

  // Tracks whether the current output holds a flag word
  logic flagword_q;
  always_ff @(posedge clk) begin
    if (rst) flagword_q <= 1'b0;
    else     flagword_q <= cmp_mode && (op_code != 4'hF);
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (result_q == '0) && !illegal_q);

  // R11
  bad_op_chk: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'hF) |=> illegal_q && (result_q == '0));

  // R11
  good_op_chk: assert property (@(posedge clk) disable iff (rst)
    (op_code != 4'hF) |=> !illegal_q);

  // R7
  flag_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_mode && op_code != 4'hF) |=> (result_q[DATA_W-1:FLAG_W] == '0));

  // R9
  no_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_mode && op_code != 4'h0 && op_code != 4'h2) |=> !result_q[1]);

  // R10
  gt_implies_ge_chk: assert property (@(posedge clk) disable iff (rst)
    (flagword_q && result_q[5]) |-> (result_q[4] && !result_q[0]));

  // R10
  above_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (flagword_q && result_q[6]) |-> (!result_q[1] && !result_q[0]));

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'h4 && !cmp_mode) |=> (result_q == $past(op_a & op_b)));
endmodule

// File: tb/sim_bitfield_alu.sv
module sim_bitfield_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [3:0]  op_code = '0;
  logic        cmp_mode = 1'b0;
  logic [1:0]  width_sel = '0;
  logic [31:0] result_q;
  logic        illegal_q;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bitfield_alu u0 (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_code(op_code),
    .cmp_mode(cmp_mode), .width_sel(width_sel),
    .result_q(result_q), .illegal_q(illegal_q)
  );

  function automatic logic [31:0] pick(int idx);
    case (idx)
      0: pick = 32'h0000_0000;  1: pick = 32'h0000_0001;
      2: pick = 32'h0000_007F;  3: pick = 32'h0000_0080;
      4: pick = 32'h0000_00FF;  5: pick = 32'h0000_7FFF;
      6: pick = 32'h0000_8000;  7: pick = 32'h0000_FFFF;
      8: pick = 32'h7FFF_FFFF;  9: pick = 32'h8000_0000;
      10: pick = 32'hFFFF_FFFF; 11: pick = 32'h1234_5678;
      default: pick = 32'hDEAD_BEEF;
    endcase
  endfunction

  function automatic logic [31:0] model_val(logic [31:0] a, logic [31:0] b, int op);
    int s, pos, len;
    logic [63:0] wide;
    logic [31:0] r;
    s   = int'(b[4:0]);
    pos = int'(b[4:0]);
    len = (b[8:5] == 0) ? 16 : int'(b[8:5]);
    r = '0;
    case (op)
      0: r = a + b;
      1: begin wide = {a, a}; r = wide[s +: 32]; end
      2: r = a - b;
      3: r = (a * 32'd1024) + {22'd0, b[9:0]};
      4: r = a & b;
      5: r = a | b;
      6: r = a ^ b;
      7: r = ~(a ^ b);
      8: r = a << s;
      9: r = a >> s;
      10: for (int i = 0; i < 32; i++) r[i] = (i + s < 32) ? a[i + s] : a[31];
      11: begin
        r = a;
        for (int j = 0; j < len; j++)
          if (pos + j < 32) r[pos + j] = b[10 + j];
      end
      12, 13: begin
        for (int j = 0; j < len; j++) r[j] = (pos + j < 32) ? a[pos + j] : 1'b0;
        if (op == 12 && r[len - 1])
          for (int j = len; j < 32; j++) r[j] = 1'b1;
      end
      14: for (int i = 0; i < 32; i++) r[i] = a[i ^ int'(b[4:0])];
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [6:0] model_flags(logic [31:0] a, logic [31:0] b, int op, int wsel);
    int w;
    logic [63:0] m, am, bm, t;
    logic [31:0] r;
    logic z, sg, ah, bh, ov, cy, ge;
    w  = (wsel == 0) ? 8 : (wsel == 1) ? 16 : 32;
    m  = (64'd1 << w) - 64'd1;
    r  = model_val(a, b, op);
    am = {32'd0, a} & m;
    bm = {32'd0, b} & m;
    z  = (({32'd0, r} & m) == 64'd0);
    sg = r[w - 1];
    ah = a[w - 1];
    bh = b[w - 1];
    ov = (sg != ah) && (ah != bh);
    cy = 1'b0;
    if (op == 0) begin t = am + bm; cy = t[w]; end
    if (op == 2) begin t = am - bm; cy = t[w]; end
    ge = (sg == ov);
    return {!cy && !z, ge && !z, ge, sg, ov, cy, z};
  endfunction

  function automatic string req_of(int op);
    case (op)
      0, 2, 4, 5, 6, 7: req_of = "R2";
      1, 3, 8, 9, 10: req_of = "R3";
      11: req_of = "R4";
      12, 13: req_of = "R5";
      14: req_of = "R6";
      default: req_of = "R11";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s a=%h b=%h op=%h cmp=%0d w=%0d got=%h exp=%h",
               req, op_a, op_b, op_code, cmp_mode, width_sel, got, exp);
    end
  endtask

  task automatic apply(logic [31:0] a, logic [31:0] b, int op, bit cm, int ws);
    @(negedge clk);
    op_a = a; op_b = b; op_code = 4'(op); cmp_mode = cm; width_sel = 2'(ws);
    @(posedge clk);
    #5;
  endtask

  task automatic run_vec(logic [31:0] a, logic [31:0] b, int op);
    logic [6:0] f;
    apply(a, b, op, 1'b0, 0);
    chk(req_of(op), result_q, model_val(a, b, op));
    chk("R11", {31'd0, illegal_q}, {31'd0, op == 15});
    for (int ws = 0; ws < 4; ws++) begin
      apply(a, b, op, 1'b1, ws);
      if (op == 15) begin
        chk("R11", {result_q[31:1], illegal_q}, 32'd1);
      end else begin
        f = model_flags(a, b, op, ws);
        chk("R7", {7'd0, result_q[31:7]}, 32'd0);
        chk("R8", {30'd0, result_q[3], result_q[0]}, {30'd0, f[3], f[0]});
        chk("R9", {30'd0, result_q[2:1]}, {30'd0, f[2:1]});
        chk("R10", {29'd0, result_q[6:4]}, {29'd0, f[6:4]});
      end
    end
  endtask

  initial begin
    logic [31:0] x;
    logic [31:0] y;
    // R1: reset under live inputs
    op_a = 32'hFFFF_FFFF; op_b = 32'h1; op_code = 4'hF;
    repeat (3) @(posedge clk);
    #5;
    chk("R1", {result_q[31:1], illegal_q}, 32'd0);
    chk("R1", result_q, 32'd0);
    @(negedge clk); rst = 1'b0;

    for (int ia = 0; ia < 13; ia++)
      for (int ib = 0; ib < 13; ib++)
        for (int op = 0; op < 16; op++)
          run_vec(pick(ia), pick(ib), op);

    // Pseudo-random operands
    x = 32'h1357_9BDF;
    y = 32'h2468_ACE0;
    for (int n = 0; n < 1200; n++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      y = y ^ (y << 7);  y = y ^ (y >> 9);  y = y ^ (y << 8);
      run_vec(x, y, n % 16);
    end

    // R12: inputs changed between edges do not move the outputs
    for (int k = 0; k < 3; k++) begin
      apply(32'h0F0F_0000 + k, 32'h0000_00F3, 0, 1'b0, 0);
      @(negedge clk);
      op_a = 32'hAAAA_5555; op_b = 32'h3; op_code = 4'h6; cmp_mode = 1'b0;
      #3;
      chk("R12", result_q, 32'h0F0F_00F3 + k);
      @(posedge clk); #5;
      chk("R12", result_q, 32'hAAAA_5556);
    end

    // R1: reset in mid-run clears registered state
    @(negedge clk);
    rst = 1'b1; op_code = 4'hF;
    @(posedge clk); #5;
    chk("R1", {result_q[31:1], illegal_q}, 32'd0);
    @(negedge clk); rst = 1'b0;

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule